// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block collects up to 32 peripheral interrupt lines and one non-maskable line. It records each request in a pending bit and picks one interrupt at a time to hand to the processor core. Each line has an enable bit, a pending bit and a 2-bit urgency value, and a single-cycle register port reaches all of them. When the controller is built, a parameter mask sets each line as edge-sensitive (pulse) or level-sensitive.

The core-facing side is a request channel: `req_valid`, `req_id` and `req_nmi` offer an interrupt, and `req_ready` accepts it. The offer reflects arbitration in the current cycle, so it may change or drop before the core accepts it, for example when a more urgent line arrives. The core owns back-pressure: while `req_ready` is low, nothing is consumed and pending state is kept. A handshake happens only in a cycle where both `req_valid` and `req_ready` are high. When a handler ends, the core pulses `done_valid` and names the handler with `done_id` or `done_nmi`. The offer in that same cycle already treats that handler as finished, so the next interrupt can be accepted with no idle cycle between handlers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, pending and priority register reads 0 and `req_valid` is low.
- R2: The word at offset 0x100 sets enables and the word at 0x180 clears them. Writing 1 to bit i sets or clears the enable of line i, and writing 0 has no effect. Reading either offset returns the current enable mask.
- R3: The word at offset 0x200 sets pending bits and the word at 0x280 clears them, with the same write-1 rule as R2. Reading either offset returns the current pending state.
- R4: The urgency value of line i is held in the word at offset 0x400 + 4*(i/4), in bits [8*(i%4)+7 : 8*(i%4)+6]. The other six bits of each byte read as 0 and ignore writes.
- R5: A pulse line sets its pending bit on a rising edge of its input. The bit becomes visible one clock later and stays set after the input falls, until it is cleared or accepted.
- R6: A level line reads as pending in the same cycle its input is high, and it stays pending while the input is high, even after a write to the clear-pending word.
- R7: Among lines that are pending, enabled and not active, the line with the lowest urgency value is offered. On a tie, the lower line number is offered. A disabled line is never offered.
- R8: While any maskable handler is active, a line is offered only if its urgency value is strictly lower than that of every active handler.
- R9: A handshake on a maskable line clears that line's latched pending bit and marks the line active. The line is not offered again until its completion.
- R10: In the cycle `done_valid` is high, the offer is computed with the named handler already retired, so the next interrupt can be accepted in that same cycle.
- R11: A rising edge on `nmi_in` makes the NMI pending. It is offered with `req_nmi`=1 ahead of every maskable line, whatever the enables or the active handlers. While it is active, no maskable line is offered. It retires through `done_nmi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Peripheral request lines |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for `reg_addr`, same cycle |
| req_valid | output | 1 | An interrupt is offered |
| req_ready | input | 1 | Core accepts the offered interrupt |
| req_id | output | ID_W | Offered line number (0 when the NMI is offered) |
| req_nmi | output | 1 | The offer is the non-maskable interrupt |
| done_valid | input | 1 | A handler has completed |
| done_nmi | input | 1 | The completed handler is the NMI |
| done_id | input | ID_W | Line number of the completed maskable handler |

## Verification
The bench builds the controller with NUM_IRQ=8 and LEVEL_MASK=8'hF0, so lines 0-3 are pulse lines and lines 4-7 are level lines. Two priority words and an 8-bit mask are small enough to sweep every pair of lines against all sixteen urgency combinations, with the winner, the tie-break and the disable fallback worked out arithmetically for each case. The same small build makes short scripted sequences enough to reach nesting, strict preemption, same-cycle chaining at completion and NMI masking.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRIO_W   = 2;
  localparam int PRIO_LSB = 6;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;

  localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_PD_SET = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_PD_CLR = 12'h280;
  localparam logic [ADDR_W-1:0] OFS_PRIO   = 12'h400;

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/pvic_line.sv
module pvic_line #(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ack_clr,
  output logic pend
);
  logic pend_q;
  logic hw_set;

  generate
    if (IS_LEVEL) begin : g_level
      assign hw_set = 1'b0;
      assign pend   = pend_q | irq_raw;
    end else begin : g_pulse
      logic raw_q;
      always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= irq_raw;
      end
      assign hw_set = irq_raw & ~raw_q;
      assign pend   = pend_q;
    end
  endgenerate

  // New occurrences win over any clear arriving in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (hw_set || sw_set) pend_q <= 1'b1;
    else if (sw_clr || ack_clr) pend_q <= 1'b0;
  end
endmodule

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            we,
  input  logic [NUM_IRQ-1:0]              pend_in,
  output logic [NUM_IRQ-1:0]              en,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio,
  output logic [NUM_IRQ-1:0]              sw_set,
  output logic [NUM_IRQ-1:0]              sw_clr,
  output logic [DATA_W-1:0]               rdata
);
  localparam int          NUM_WORDS = (NUM_IRQ + 3) / 4;
  localparam logic [3:0]  NW        = 4'(NUM_WORDS);

  logic hit_en_set, hit_en_clr, hit_pd_set, hit_pd_clr, prio_sel;
  logic [NUM_IRQ-1:0] wbits;

  assign wbits      = wdata[NUM_IRQ-1:0];
  assign hit_en_set = we && (addr == OFS_EN_SET);
  assign hit_en_clr = we && (addr == OFS_EN_CLR);
  assign hit_pd_set = we && (addr == OFS_PD_SET);
  assign hit_pd_clr = we && (addr == OFS_PD_CLR);
  assign prio_sel   = (addr[ADDR_W-1:5] == OFS_PRIO[ADDR_W-1:5]) &&
                      ({1'b0, addr[4:2]} < NW) && (addr[1:0] == 2'b00);

  assign sw_set = hit_pd_set ? wbits : '0;
  assign sw_clr = hit_pd_clr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else if (hit_en_set) en <= en | wbits;
    else if (hit_en_clr) en <= en & ~wbits;
  end

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
      localparam int WORD = i / 4;
      localparam int MSB  = 8 * (i % 4) + PRIO_LSB + PRIO_W - 1;
      always_ff @(posedge clk) begin
        if (!rst_n)
          prio[i] <= '0;
        else if (we && prio_sel && (addr[4:2] == 3'(WORD)))
          prio[i] <= wdata[MSB -: PRIO_W];
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == OFS_EN_SET || addr == OFS_EN_CLR)
      rdata[NUM_IRQ-1:0] = en;
    else if (addr == OFS_PD_SET || addr == OFS_PD_CLR)
      rdata[NUM_IRQ-1:0] = pend_in;
    else if (prio_sel) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (addr[4:2] == 3'(i / 4))
          rdata[8 * (i % 4) + PRIO_LSB +: PRIO_W] = prio[i];
      end
    end
  end
endmodule

// File: rtl/pvic_select.sv
module pvic_select
  import pvic_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ID_W    = 5
) (
  input  logic [NUM_IRQ-1:0]             cand,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output logic                           best_vld,
  output logic [ID_W-1:0]                best_id,
  output logic [PRIO_W-1:0]              best_prio
);
  // Scan from the top down with <= so that ties settle on the lowest index
  always_comb begin
    best_vld  = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand[i] && (!best_vld || prio[i] <= best_prio)) begin
        best_vld  = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pvic_pkg::*;
#(
  parameter int                 NUM_IRQ    = 32,
  parameter logic [NUM_IRQ-1:0] LEVEL_MASK = '0,
  localparam int                ID_W       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_we,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ID_W-1:0]    req_id,
  output logic               req_nmi,
  input  logic               done_valid,
  input  logic               done_nmi,
  input  logic [ID_W-1:0]    done_id
);
  logic [NUM_IRQ-1:0]             line_en, line_pend, sw_set, sw_clr;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] line_prio;
  logic [NUM_IRQ-1:0]             active_q, act_eff, done_clr, ack_set, cand;
  logic                           best_vld;
  logic [ID_W-1:0]                best_id;
  logic [PRIO_W-1:0]              best_prio;
  logic [PRIO_W:0]                run_prio;
  logic                           nmi_q, nmi_pend_q, nmi_act_q, nmi_act_eff, nmi_offer;
  logic                           accept;

  pvic_regs #(.NUM_IRQ(NUM_IRQ)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .pend_in(line_pend), .en(line_en), .prio(line_prio),
    .sw_set(sw_set), .sw_clr(sw_clr), .rdata(reg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      pvic_line #(.IS_LEVEL(LEVEL_MASK[i])) line_i (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_in[i]),
        .sw_set(sw_set[i]), .sw_clr(sw_clr[i]), .ack_clr(ack_set[i]),
        .pend(line_pend[i])
      );
      assign done_clr[i] = done_valid && !done_nmi && (done_id == ID_W'(i));
      assign ack_set[i]  = accept && !req_nmi && (req_id == ID_W'(i));
    end
  endgenerate

  // Handlers retiring this cycle no longer hold the running priority
  assign act_eff     = active_q & ~done_clr;
  assign nmi_act_eff = nmi_act_q && !(done_valid && done_nmi);
  assign cand        = line_pend & line_en & ~act_eff;

  always_comb begin
    run_prio = (PRIO_W + 1)'(1 << PRIO_W);
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (act_eff[i] && ({1'b0, line_prio[i]} < run_prio))
        run_prio = {1'b0, line_prio[i]};
    end
  end

  pvic_select #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) sel_i (
    .cand(cand), .prio(line_prio),
    .best_vld(best_vld), .best_id(best_id), .best_prio(best_prio)
  );

  assign nmi_offer = nmi_pend_q && !nmi_act_eff;
  assign req_valid = nmi_offer ||
                     (!nmi_act_eff && best_vld && ({1'b0, best_prio} < run_prio));
  assign req_nmi   = nmi_offer;
  assign req_id    = nmi_offer ? '0 : best_id;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= '0;
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
      nmi_act_q  <= 1'b0;
    end else begin
      active_q  <= act_eff | ack_set;
      nmi_q     <= nmi_in;
      if (nmi_in && !nmi_q)          nmi_pend_q <= 1'b1;
      else if (accept && req_nmi)    nmi_pend_q <= 1'b0;
      nmi_act_q <= nmi_act_eff || (accept && req_nmi);
    end
  end
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
  import pvic_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ID_W    = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic                           req_ready,
  input logic                           req_nmi,
  input logic [ID_W-1:0]                req_id,
  input logic [NUM_IRQ-1:0]             line_en,
  input logic [NUM_IRQ-1:0][PRIO_W-1:0] line_prio,
  input logic [NUM_IRQ-1:0]             act_eff,
  input logic [NUM_IRQ-1:0]             active_q,
  input logic                           nmi_pend_q,
  input logic                           nmi_act_eff,
  input logic [PRIO_W:0]                run_prio,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [DATA_W-1:0]              reg_rdata
);
  AST_ACCEPT_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_nmi) |=> active_q[$past(req_id)]); // R9
  AST_OFFER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi) |-> (line_en[req_id] && !act_eff[req_id])); // R7
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi) |-> ({1'b0, line_prio[req_id]} < run_prio)); // R8
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !nmi_act_eff) |-> (req_valid && req_nmi)); // R11
  AST_NMI_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_act_eff |-> !(req_valid && !req_nmi)); // R11
  AST_PRIO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:5] == OFS_PRIO[ADDR_W-1:5]) |-> ((reg_rdata & 32'h3F3F3F3F) == '0)); // R4
endmodule

bind prio_irq_ctrl pvic_checker #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_nmi(req_nmi), .req_id(req_id), .line_en(line_en), .line_prio(line_prio),
  .act_eff(act_eff), .active_q(active_q), .nmi_pend_q(nmi_pend_q),
  .nmi_act_eff(nmi_act_eff), .run_prio(run_prio), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int N    = 8;
  localparam int ID_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        nmi_in = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_nmi;
  logic        req_ready = 1'b0;
  logic [ID_W-1:0] req_id;
  logic        done_valid = 1'b0, done_nmi = 1'b0;
  logic [ID_W-1:0] done_id = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] pr [N];
  logic [31:0] v;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N), .LEVEL_MASK(8'hF0)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_nmi(req_nmi), .done_valid(done_valid),
    .done_nmi(done_nmi), .done_id(done_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] pword(input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++) w |= 32'(pr[4*k+j]) << (8*j + 6);
    return w;
  endfunction

  task automatic accept_now();
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    #1;
  endtask

  task automatic offer(input string tag, input logic vld, input logic nmi, input int id);
    #1;
    chk({tag, " valid"}, 32'(req_valid), 32'(vld));
    if (vld) begin
      chk({tag, " nmi"}, 32'(req_nmi), 32'(nmi));
      chk({tag, " id"}, 32'(req_id), 32'(id));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) pr[i] = 2'd0;
    repeat (3) tick();
    rst_n = 1'b1;

    // R1: reset state
    rd(12'h100, v); chk("R1 enable", v, 0);
    rd(12'h180, v); chk("R1 enable alias", v, 0);
    rd(12'h200, v); chk("R1 pending", v, 0);
    rd(12'h280, v); chk("R1 pending alias", v, 0);
    rd(12'h400, v); chk("R1 prio0", v, 0);
    rd(12'h404, v); chk("R1 prio1", v, 0);
    chk("R1 no offer", 32'(req_valid), 0);

    // R2: enable aliases
    for (int i = 0; i < N; i++) begin
      wr(12'h100, 32'(1 << i));
      rd(12'h100, v); chk("R2 set", v, 32'((1 << (i + 1)) - 1));
      rd(12'h180, v); chk("R2 alias", v, 32'((1 << (i + 1)) - 1));
    end
    wr(12'h100, 0); rd(12'h100, v); chk("R2 zero write", v, 32'hFF);
    wr(12'h180, 0); rd(12'h180, v); chk("R2 zero clear", v, 32'hFF);
    for (int i = 0; i < N; i++) begin
      wr(12'h180, 32'(1 << i));
      rd(12'h100, v); chk("R2 clear", v, 32'hFF & ~32'((1 << (i + 1)) - 1));
    end

    // R3: pending aliases
    for (int i = 0; i < N; i++) begin
      wr(12'h200, 32'(1 << i));
      rd(12'h280, v); chk("R3 set", v, 32'((1 << (i + 1)) - 1));
    end
    wr(12'h280, 0); rd(12'h200, v); chk("R3 zero clear", v, 32'hFF);
    wr(12'h280, 32'h0F); rd(12'h200, v); chk("R3 clear", v, 32'hF0);
    wr(12'h280, 32'hF0); rd(12'h280, v); chk("R3 clear all", v, 0);
    chk("R3 disabled no offer", 32'(req_valid), 0);

    // R4: priority fields
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 256; p += 37) begin
        logic [31:0] d = {8'(p), 8'(p + 64), 8'(p + 128), 8'(p + 192)};
        wr(12'(12'h400 + 4 * k), d);
        rd(12'(12'h400 + 4 * k), v); chk("R4 field", v, d & 32'hC0C0C0C0);
      end
      wr(12'(12'h400 + 4 * k), 32'hFFFFFFFF);
      rd(12'(12'h400 + 4 * k), v); chk("R4 ones", v, 32'hC0C0C0C0);
      wr(12'(12'h400 + 4 * k), 0);
    end

    // R5: pulse line edge
    irq_in[2] = 1'b1;
    rd(12'h200, v); chk("R5 not before edge", v, 0);
    tick();
    rd(12'h200, v); chk("R5 latched", v, 32'h04);
    irq_in[2] = 1'b0; tick();
    rd(12'h200, v); chk("R5 held", v, 32'h04);
    wr(12'h280, 32'h04); rd(12'h200, v); chk("R5 cleared", v, 0);

    // R6: level line
    irq_in[5] = 1'b1;
    rd(12'h200, v); chk("R6 immediate", v, 32'h20);
    wr(12'h280, 32'h20); rd(12'h200, v); chk("R6 clear ignored", v, 32'h20);
    irq_in[5] = 1'b0;
    rd(12'h200, v); chk("R6 released", v, 0);

    // R7: pairwise priority sweep
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        for (int pa = 0; pa < 4; pa++) begin
          for (int pb = 0; pb < 4; pb++) begin
            int win, lose;
            for (int i = 0; i < N; i++) pr[i] = 2'd0;
            pr[a] = 2'(pa); pr[b] = 2'(pb);
            wr(12'h400, pword(0));
            wr(12'h404, pword(1));
            wr(12'h100, 32'((1 << a) | (1 << b)));
            wr(12'h200, 32'((1 << a) | (1 << b)));
            win  = (pb < pa) ? b : a;
            lose = (win == a) ? b : a;
            offer("R7 winner", 1'b1, 1'b0, win);
            wr(12'h180, 32'(1 << win));
            offer("R7 disabled skipped", 1'b1, 1'b0, lose);
            wr(12'h180, 32'(1 << lose));
            offer("R7 none enabled", 1'b0, 1'b0, 0);
            wr(12'h280, 32'hFF);
          end
        end
      end
    end

    // R8 / R9 / R10: nesting and chaining
    for (int i = 0; i < N; i++) pr[i] = 2'd0;
    pr[1] = 2'd2; pr[2] = 2'd2; pr[3] = 2'd1;
    wr(12'h400, pword(0)); wr(12'h404, pword(1));
    wr(12'h100, 32'h0F);
    wr(12'h200, 32'h04);
    offer("R9 offer", 1'b1, 1'b0, 2);
    accept_now();
    rd(12'h200, v); chk("R9 pending cleared", v, 0);
    offer("R9 not reoffered", 1'b0, 1'b0, 0);
    wr(12'h200, 32'h02);
    offer("R8 equal blocked", 1'b0, 1'b0, 0);
    wr(12'h200, 32'h08);
    offer("R8 lower preempts", 1'b1, 1'b0, 3);
    accept_now();
    wr(12'h200, 32'h01);
    offer("R8 nested", 1'b1, 1'b0, 0);
    accept_now();
    offer("R8 three deep", 1'b0, 1'b0, 0);
    done_valid = 1'b1; done_id = 3'd0;
    offer("R10 still blocked", 1'b0, 1'b0, 0);
    tick();
    done_id = 3'd3;
    offer("R10 equal after retire", 1'b0, 1'b0, 0);
    tick();
    done_id = 3'd2;
    offer("R10 same cycle chain", 1'b1, 1'b0, 1);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0; done_valid = 1'b0;
    rd(12'h200, v); chk("R10 chained accepted", v, 0);
    offer("R10 idle after chain", 1'b0, 1'b0, 0);
    done_valid = 1'b1; done_id = 3'd1; tick(); done_valid = 1'b0;

    // R11: non-maskable
    wr(12'h180, 32'hFF);
    nmi_in = 1'b1; tick();
    offer("R11 nmi ungated", 1'b1, 1'b1, 0);
    accept_now();
    nmi_in = 1'b0;
    wr(12'h100, 32'h01); wr(12'h200, 32'h01);
    offer("R11 masks maskable", 1'b0, 1'b0, 0);
    done_valid = 1'b1; done_nmi = 1'b1;
    offer("R11 chain after nmi", 1'b1, 1'b0, 0);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0; done_valid = 1'b0; done_nmi = 1'b0;
    nmi_in = 1'b1; tick();
    offer("R11 preempts urgent handler", 1'b1, 1'b1, 0);
    accept_now();
    nmi_in = 1'b0;
    done_valid = 1'b1; done_nmi = 1'b1; tick();
    done_nmi = 1'b0; done_id = 3'd0; tick();
    done_valid = 1'b0;
    offer("R11 all retired", 1'b0, 1'b0, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule